// File: doc/BRIEF.md
# Parallel Flash Command Front End

This block is the control front end of a 128K x 8 parallel flash device. It samples the chip-select, output-enable and write-strobe pins (all active low) into the core clock domain. It turns them into one of four bus modes: read, output off, standby and command write. In read mode it drives the addressed byte from a behavioural cell array onto the data bus. The bus is a data vector paired with an output-enable, and the pad cell sits outside the block.

Each qualified write strobe loads a command latch. The address is taken when the strobe goes low and the data when it returns high. A two-write protocol then issues single-cycle program or erase requests to the cell back end. A parameterized busy timer stands in for the internal operation, and its done pulse reopens the write path. Erase is held off after reset until the device has proven it is not blank. Either a byte program has taken place, or a read in erase-verify mode has returned something other than FFh.

Top module: `flash_cmd_front`

## Requirements
- R1: With chip-select low and output-enable low, `dq_oe` is 1 and `dq_out` equals the array byte at the address pins.
- R2: With output-enable high, `dq_oe` is 0.
- R3: With chip-select high, `dq_oe` is 0 whatever output-enable and the write strobe do, and this holds from reset.
- R4: While `vpp_hi` is 0, write strobes have no effect: a program sequence produces no request and no busy period.
- R5: A write strobe made while output-enable is low, or while `supply_low` is 1, has no effect.
- R6: A command write takes the address present when the strobe falls and the data present when it rises. Pins are held stable for at least SYNC_STAGES+2 clock cycles around each strobe edge.
- R7: Data 40h followed by a second write issues exactly one `prog_req` pulse carrying that second write's address and data, after which `op_busy` is high for exactly BUSY_CYCLES cycles.
- R8: Write strobes made while an operation is busy are ignored and leave the command state unchanged.
- R9: Data 20h written twice in a row issues one `erase_req` pulse, but only when erase is enabled; otherwise nothing is issued and the device returns to read.
- R10: Erase becomes enabled when a byte program is issued, or when a read made in erase-verify mode (entered by data A0h) returns a byte other than FFh. An FFh verify read does not enable it.
- R11: Any first-write data other than 00h, 40h, 20h or A0h returns the device to read, so the next write is taken as a new command.
- R12: Erase enable is cleared by reset and, once set, stays set until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, stands for power-up |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write strobe, active low |
| addr | input | ADDR_W | Byte address pins |
| dq_in | input | DATA_W | Data bus value seen at the pins |
| vpp_hi | input | 1 | Programming supply is at its high level |
| supply_low | input | 1 | Logic supply below its safe level |
| dq_out | output | DATA_W | Data driven toward the bus |
| dq_oe | output | 1 | Bus driver enable; 0 means high impedance |
| arr_addr | output | ADDR_W | Read address to the cell array |
| arr_rdata | input | DATA_W | Read data from the cell array |
| prog_req | output | 1 | One-cycle byte program request |
| erase_req | output | 1 | One-cycle erase request |
| req_addr | output | ADDR_W | Address belonging to the request |
| req_data | output | DATA_W | Data belonging to the request |
| op_busy | output | 1 | Internal operation in progress |
| op_done | output | 1 | One-cycle pulse in the last busy cycle |

## Verification
The command path is driven with complete two-write sequences under each inhibiting condition: programming supply low, output-enable low, supply low, and an operation already busy. It is also driven with unknown first codes. Since any of these would otherwise produce a request, a missing or extra scoreboard item shows which gate failed. Every write moves the address pins after the falling strobe and the data pins before the rising one, so a latch taken at the wrong edge shows up as a wrong address or data.

Erase is tried right after reset, after an all-FFh verify read, after a non-FFh verify read, and after a program. This separates the two enabling routes from the blank case, and a second reset shows that the flag clears. Reads at several addresses, with the two enables toggled in turn, separate the read, output-off and standby modes.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

   typedef enum logic [2:0] {
      ST_READ,
      ST_PSETUP,
      ST_ESETUP,
      ST_VERIFY,
      ST_BUSY
   } ctl_state_e;

   localparam logic [7:0] CMD_READ   = 8'h00;
   localparam logic [7:0] CMD_PROG   = 8'h40;
   localparam logic [7:0] CMD_ERASE  = 8'h20;
   localparam logic [7:0] CMD_VERIFY = 8'hA0;
   localparam logic [7:0] BLANK_BYTE = 8'hFF;

   // bit positions of the pins in the synchronizer vector
   localparam int PIN_CE    = 0;
   localparam int PIN_OE    = 1;
   localparam int PIN_WE    = 2;
   localparam int PIN_VPP   = 3;
   localparam int PIN_VLOW  = 4;
   localparam int PIN_COUNT = 5;

endpackage

// File: rtl/flash_pin_sync.sv
module flash_pin_sync #(
   parameter int                 WIDTH   = 5,
   parameter int                 STAGES  = 2,
   parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);

   if (STAGES < 2) begin : g_bad_stages
      $error("flash_pin_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("flash_pin_sync: WIDTH must be positive");
   end

   logic [STAGES-1:0][WIDTH-1:0] pipe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pipe <= {STAGES{RST_VAL}};
      end else begin
         pipe <= {pipe[STAGES-2:0], din};
      end
   end

   assign dout = pipe[STAGES-1];

endmodule

// File: rtl/flash_op_timer.sv
module flash_op_timer #(
   parameter int CYCLES = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy,
   output logic done
);

   if (CYCLES < 1) begin : g_bad_cycles
      $error("flash_op_timer: CYCLES must be at least 1");
   end

   localparam int CW = $clog2(CYCLES + 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (start) begin
         cnt <= CW'(CYCLES);
      end else if (cnt != '0) begin
         cnt <= cnt - 1'b1;
      end
   end

   assign busy = (cnt != '0);
   assign done = (cnt == CW'(1));

   // R7: the done pulse closes the busy window
   a_r7_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
      done && !start |=> !busy)
      else $error("a_r7_done_ends_busy");

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
   import flash_cmd_pkg::*;
#(
   parameter int ADDR_W = 17,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_s,
   input  logic              oe_s,
   input  logic              vpp_s,
   input  logic              vlow_s,
   input  logic              we_fall,
   input  logic              we_rise,
   input  logic              oe_fall,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] din,
   input  logic [DATA_W-1:0] rd_data,
   input  logic              op_done,
   output logic              prog_req,
   output logic              erase_req,
   output logic [ADDR_W-1:0] req_addr,
   output logic [DATA_W-1:0] req_data,
   output logic              erase_en
);

   ctl_state_e        state;
   logic              armed;
   logic [ADDR_W-1:0] lat_addr;
   logic              wr_allow;
   logic              cmd_wr;
   logic              verify_hit;

   assign wr_allow   = !ce_s && oe_s && vpp_s && !vlow_s && (state != ST_BUSY);
   assign cmd_wr     = we_rise && armed && wr_allow;
   assign verify_hit = (state == ST_VERIFY) && oe_fall && !ce_s &&
                       (rd_data != BLANK_BYTE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_READ;
         armed     <= 1'b0;
         lat_addr  <= '0;
         prog_req  <= 1'b0;
         erase_req <= 1'b0;
         req_addr  <= '0;
         req_data  <= '0;
         erase_en  <= 1'b0;
      end else begin
         prog_req  <= 1'b0;
         erase_req <= 1'b0;

         // address side of the latch: falling strobe
         if (we_fall) begin
            armed <= wr_allow;
            if (wr_allow) begin
               lat_addr <= addr;
            end
         end else if (we_rise) begin
            armed <= 1'b0;
         end

         // data side of the latch: rising strobe
         if (cmd_wr) begin
            unique case (state)
               ST_PSETUP: begin
                  prog_req <= 1'b1;
                  req_addr <= lat_addr;
                  req_data <= din;
                  erase_en <= 1'b1;
                  state    <= ST_BUSY;
               end
               ST_ESETUP: begin
                  if ((din == CMD_ERASE) && erase_en) begin
                     erase_req <= 1'b1;
                     req_addr  <= lat_addr;
                     req_data  <= din;
                     state     <= ST_BUSY;
                  end else begin
                     state <= ST_READ;
                  end
               end
               default: begin
                  case (din)
                     CMD_PROG:   state <= ST_PSETUP;
                     CMD_ERASE:  state <= ST_ESETUP;
                     CMD_VERIFY: state <= ST_VERIFY;
                     default:    state <= ST_READ;
                  endcase
               end
            endcase
         end

         if ((state == ST_BUSY) && op_done) begin
            state <= ST_READ;
         end

         if (verify_hit) begin
            erase_en <= 1'b1;
         end
      end
   end

   // R9: an erase request only ever follows an enabled flag
   a_r9_erase_gated: assert property (@(posedge clk) disable iff (!rst_n)
      erase_req |-> $past(erase_en))
      else $error("a_r9_erase_gated");

   // R12: the enable flag never falls without reset
   a_r12_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      erase_en |=> erase_en)
      else $error("a_r12_flag_sticky");

   // R7: the two request kinds never coincide
   a_r7_one_kind: assert property (@(posedge clk) disable iff (!rst_n)
      !(prog_req && erase_req))
      else $error("a_r7_one_kind");

endmodule

// File: rtl/flash_cmd_front.sv
module flash_cmd_front
   import flash_cmd_pkg::*;
#(
   parameter int ADDR_W      = 17,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter int BUSY_CYCLES = 16,
   parameter bit REG_READ    = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic              we_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] dq_in,
   input  logic              vpp_hi,
   input  logic              supply_low,
   output logic [DATA_W-1:0] dq_out,
   output logic              dq_oe,
   output logic [ADDR_W-1:0] arr_addr,
   input  logic [DATA_W-1:0] arr_rdata,
   output logic              prog_req,
   output logic              erase_req,
   output logic [ADDR_W-1:0] req_addr,
   output logic [DATA_W-1:0] req_data,
   output logic              op_busy,
   output logic              op_done
);

   if (DATA_W != 8) begin : g_bad_data_w
      $error("flash_cmd_front: command codes need DATA_W of 8");
   end
   if (ADDR_W < 1) begin : g_bad_addr_w
      $error("flash_cmd_front: ADDR_W must be positive");
   end

   // idle levels held in reset: strobes high, VPP low, supply flagged low
   localparam logic [PIN_COUNT-1:0] PIN_IDLE = 5'b10111;

   logic [PIN_COUNT-1:0] pins_raw;
   logic [PIN_COUNT-1:0] pins_s;
   logic                 ce_s, oe_s, we_s, vpp_s, vlow_s;
   logic                 we_q, oe_q;
   logic                 we_fall, we_rise, oe_fall;
   logic                 erase_en;

   assign pins_raw[PIN_CE]   = ce_n;
   assign pins_raw[PIN_OE]   = oe_n;
   assign pins_raw[PIN_WE]   = we_n;
   assign pins_raw[PIN_VPP]  = vpp_hi;
   assign pins_raw[PIN_VLOW] = supply_low;

   flash_pin_sync #(
      .WIDTH   (PIN_COUNT),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (PIN_IDLE)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (pins_raw),
      .dout  (pins_s)
   );

   assign ce_s   = pins_s[PIN_CE];
   assign oe_s   = pins_s[PIN_OE];
   assign we_s   = pins_s[PIN_WE];
   assign vpp_s  = pins_s[PIN_VPP];
   assign vlow_s = pins_s[PIN_VLOW];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         we_q <= 1'b1;
         oe_q <= 1'b1;
      end else begin
         we_q <= we_s;
         oe_q <= oe_s;
      end
   end

   assign we_fall = we_q && !we_s;
   assign we_rise = !we_q && we_s;
   assign oe_fall = oe_q && !oe_s;

   flash_cmd_ctrl #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .ce_s      (ce_s),
      .oe_s      (oe_s),
      .vpp_s     (vpp_s),
      .vlow_s    (vlow_s),
      .we_fall   (we_fall),
      .we_rise   (we_rise),
      .oe_fall   (oe_fall),
      .addr      (addr),
      .din       (dq_in),
      .rd_data   (arr_rdata),
      .op_done   (op_done),
      .prog_req  (prog_req),
      .erase_req (erase_req),
      .req_addr  (req_addr),
      .req_data  (req_data),
      .erase_en  (erase_en)
   );

   flash_op_timer #(
      .CYCLES (BUSY_CYCLES)
   ) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .start (prog_req || erase_req),
      .busy  (op_busy),
      .done  (op_done)
   );

   // read path
   assign arr_addr = addr;
   assign dq_oe    = !ce_s && !oe_s;

   if (REG_READ) begin : g_read_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            dq_out <= '0;
         end else begin
            dq_out <= arr_rdata;
         end
      end
   end else begin : g_read_comb
      assign dq_out = arr_rdata;
   end

   // R7: a program request opens a busy window on the next cycle
   a_r7_req_starts_busy: assert property (@(posedge clk) disable iff (!rst_n)
      prog_req |=> op_busy)
      else $error("a_r7_req_starts_busy");

   // R8: no request is issued inside a busy window
   a_r8_busy_no_req: assert property (@(posedge clk) disable iff (!rst_n)
      op_busy |-> !prog_req && !erase_req)
      else $error("a_r8_busy_no_req");

endmodule

// File: tb/flash_cmd_front_test.sv
module flash_cmd_front_test;

   localparam int CLK_PERIOD = 10;
   localparam int AW   = 17;
   localparam int DW   = 8;
   localparam int BUSY = 80;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] dq_in = '0;
   logic          vpp_hi = 1'b1, supply_low = 1'b0;
   logic [DW-1:0] dq_out;
   logic          dq_oe;
   logic [AW-1:0] arr_addr;
   logic [DW-1:0] arr_rdata;
   logic          prog_req, erase_req, op_busy, op_done;
   logic [AW-1:0] req_addr;
   logic [DW-1:0] req_data;

   int  compared = 0;
   int  mismatched = 0;
   bit  blank = 1'b0;
   bit  finished = 1'b0;
   int  run_len = 0;
   int  last_len = 0;

   typedef struct {
      bit          is_erase;
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      string       tag;
   } exp_t;

   exp_t sbq[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [DW-1:0] model(input logic [AW-1:0] a);
      return blank ? 8'hFF : (a[7:0] ^ 8'h3C ^ {a[16:12], 3'b000});
   endfunction

   assign arr_rdata = model(arr_addr);

   flash_cmd_front #(
      .ADDR_W      (AW),
      .DATA_W      (DW),
      .SYNC_STAGES (2),
      .BUSY_CYCLES (BUSY),
      .REG_READ    (1'b0)
   ) uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .ce_n       (ce_n),
      .oe_n       (oe_n),
      .we_n       (we_n),
      .addr       (addr),
      .dq_in      (dq_in),
      .vpp_hi     (vpp_hi),
      .supply_low (supply_low),
      .dq_out     (dq_out),
      .dq_oe      (dq_oe),
      .arr_addr   (arr_addr),
      .arr_rdata  (arr_rdata),
      .prog_req   (prog_req),
      .erase_req  (erase_req),
      .req_addr   (req_addr),
      .req_data   (req_data),
      .op_busy    (op_busy),
      .op_done    (op_done)
   );

   task automatic check(input bit ok, input string tag,
                        input logic [31:0] act, input logic [31:0] exp);
      compared++;
      if (!ok) begin
         mismatched++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic report();
      if (!finished) begin
         finished = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   endtask

   // monitor: every request is popped against the scoreboard
   always @(negedge clk) begin
      exp_t e;
      if (rst_n && (prog_req || erase_req)) begin
         compared++;
         if (sbq.size() == 0) begin
            mismatched++;
            $display("FAIL R4/R5/R8/R9/R11: unexpected request erase=%0d addr=%h data=%h, expected none",
                     erase_req, req_addr, req_data);
         end else begin
            e = sbq.pop_front();
            if (erase_req != e.is_erase || prog_req == e.is_erase ||
                req_addr != e.a || (!e.is_erase && req_data != e.d)) begin
               mismatched++;
               $display("FAIL %s: actual erase=%0d addr=%h data=%h expected erase=%0d addr=%h data=%h",
                        e.tag, erase_req, req_addr, req_data, e.is_erase, e.a, e.d);
            end
         end
      end
   end

   // busy window length measurement
   always @(negedge clk) begin
      if (op_busy) begin
         run_len++;
      end else begin
         if (run_len != 0) last_len = run_len;
         run_len = 0;
      end
   end

   // watchdog
   initial begin
      repeat (150000) @(posedge clk);
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
   end

   task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit oe_low);
      @(negedge clk);
      addr  = a;
      dq_in = d ^ 8'hA5;
      oe_n  = oe_low ? 1'b0 : 1'b1;
      ce_n  = 1'b0;
      repeat (4) @(negedge clk);
      we_n = 1'b0;
      repeat (6) @(negedge clk);
      addr  = a ^ 17'h15A5A;   // R6: address moves after the falling strobe
      dq_in = d;               // R6: data settles before the rising strobe
      repeat (6) @(negedge clk);
      we_n = 1'b1;
      repeat (6) @(negedge clk);
      ce_n = 1'b1;
      oe_n = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   task automatic bus_read(input logic [AW-1:0] a, input string tag);
      @(negedge clk);
      addr = a;
      ce_n = 1'b0;
      oe_n = 1'b0;
      repeat (6) @(negedge clk);
      check(dq_oe === 1'b1, tag, 32'(dq_oe), 32'd1);
      check(dq_out === model(a), tag, 32'(dq_out), 32'(model(a)));
      oe_n = 1'b1;
      repeat (5) @(negedge clk);
      check(dq_oe === 1'b0, "R2", 32'(dq_oe), 32'd0);
      ce_n = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   task automatic wait_op();
      while (!op_busy) @(negedge clk);
      while (op_busy) @(negedge clk);
      repeat (4) @(negedge clk);
   endtask

   task automatic erase_try(input logic [AW-1:0] a);
      bus_write(a, 8'h20, 1'b0);
      bus_write(a, 8'h20, 1'b0);
   endtask

   task automatic push(input bit er, input logic [AW-1:0] a,
                       input logic [DW-1:0] d, input string tag);
      exp_t e;
      e.is_erase = er;
      e.a = a;
      e.d = d;
      e.tag = tag;
      sbq.push_back(e);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
   endtask

   initial begin
      // ---------- phase A ----------
      do_reset();
      check(dq_oe === 1'b0, "R3", 32'(dq_oe), 32'd0);
      check(op_busy === 1'b0, "R9", 32'(op_busy), 32'd0);

      bus_read(17'h00000, "R1");
      bus_read(17'h1F0A3, "R1");
      bus_read(17'h0AAAA, "R1");

      // standby: chip select high, output enable low, strobe toggling
      @(negedge clk);
      ce_n = 1'b1;
      oe_n = 1'b0;
      addr = 17'h00123;
      repeat (3) begin
         repeat (3) @(negedge clk);
         we_n = 1'b0;
         repeat (3) @(negedge clk);
         we_n = 1'b1;
      end
      repeat (3) @(negedge clk);
      check(dq_oe === 1'b0, "R3", 32'(dq_oe), 32'd0);
      oe_n = 1'b1;
      repeat (4) @(negedge clk);

      // erase straight after reset is refused
      erase_try(17'h00400);
      repeat (6) @(negedge clk);
      check(op_busy === 1'b0, "R9", 32'(op_busy), 32'd0);

      // verify on a blank array does not enable erase
      blank = 1'b1;
      bus_write(17'h00005, 8'hA0, 1'b0);
      bus_read(17'h00005, "R10");
      bus_write(17'h00000, 8'h00, 1'b0);
      erase_try(17'h00400);
      repeat (6) @(negedge clk);
      check(op_busy === 1'b0, "R10", 32'(op_busy), 32'd0);

      // verify on a non-blank byte enables erase
      blank = 1'b0;
      bus_write(17'h00010, 8'hA0, 1'b0);
      bus_read(17'h00010, "R10");
      bus_write(17'h00000, 8'h00, 1'b0);
      push(1'b1, 17'h00400, 8'h20, "R9/R10");
      erase_try(17'h00400);
      wait_op();
      check(sbq.size() == 0, "R9", 32'(sbq.size()), 32'd0);

      // flag stays set
      push(1'b1, 17'h01800, 8'h20, "R12");
      erase_try(17'h01800);
      wait_op();
      check(sbq.size() == 0, "R12", 32'(sbq.size()), 32'd0);

      // ---------- phase B ----------
      do_reset();
      erase_try(17'h00400);
      repeat (6) @(negedge clk);
      check(op_busy === 1'b0, "R12", 32'(op_busy), 32'd0);

      // programming supply low
      vpp_hi = 1'b0;
      repeat (5) @(negedge clk);
      bus_write(17'h00100, 8'h40, 1'b0);
      bus_write(17'h00100, 8'h5A, 1'b0);
      repeat (6) @(negedge clk);
      check(op_busy === 1'b0, "R4", 32'(op_busy), 32'd0);
      vpp_hi = 1'b1;
      repeat (5) @(negedge clk);

      // output enable low during the strobes
      bus_write(17'h00101, 8'h40, 1'b1);
      bus_write(17'h00101, 8'h77, 1'b1);
      repeat (6) @(negedge clk);
      check(op_busy === 1'b0, "R5", 32'(op_busy), 32'd0);

      // supply low during the strobes
      supply_low = 1'b1;
      repeat (5) @(negedge clk);
      bus_write(17'h00102, 8'h40, 1'b0);
      bus_write(17'h00102, 8'h66, 1'b0);
      repeat (6) @(negedge clk);
      check(op_busy === 1'b0, "R5", 32'(op_busy), 32'd0);
      supply_low = 1'b0;
      repeat (5) @(negedge clk);

      // unknown codes fall back to read
      bus_write(17'h00200, 8'h77, 1'b0);
      bus_write(17'h00200, 8'h12, 1'b0);
      bus_write(17'h00201, 8'h55, 1'b0);
      bus_write(17'h00201, 8'h34, 1'b0);
      repeat (6) @(negedge clk);
      check(op_busy === 1'b0, "R11", 32'(op_busy), 32'd0);
      bus_read(17'h00201, "R11");

      // valid program, with strobes attempted during busy
      push(1'b0, 17'h0ABCD, 8'h5A, "R6/R7");
      bus_write(17'h0ABCD, 8'h40, 1'b0);
      bus_write(17'h0ABCD, 8'h5A, 1'b0);
      check(op_busy === 1'b1, "R7", 32'(op_busy), 32'd1);
      bus_write(17'h00042, 8'h40, 1'b0);   // R8: ignored while busy
      check(op_busy === 1'b1, "R8", 32'(op_busy), 32'd1);
      while (op_busy) @(negedge clk);
      repeat (3) @(negedge clk);
      check(last_len == BUSY, "R7", 32'(last_len), 32'(BUSY));
      bus_write(17'h00042, 8'h99, 1'b0);   // would program if the setup had stuck
      repeat (6) @(negedge clk);
      check(op_busy === 1'b0, "R8", 32'(op_busy), 32'd0);

      // program enabled erase
      push(1'b1, 17'h00C00, 8'h20, "R10");
      erase_try(17'h00C00);
      wait_op();
      check(sbq.size() == 0, "R10", 32'(sbq.size()), 32'd0);

      repeat (10) @(negedge clk);
      report();
   end

endmodule